// File: doc/BRIEF.md
# Temperature Limit Alert and Status Flags

This block sits beside a temperature converter. It checks every finished conversion against a programmable upper and lower limit and drives an alert pin. The alert has hysteresis: it is raised when a result lands above the upper limit and dropped only when a later result lands below the lower limit, when software writes a one to the reset bit of the configuration byte, or when an external alert-response clear pulse arrives. The same register bank also keeps two sticky status flags, one for "above upper" and one for "below lower". Each flag holds until a status read happens at a time when its condition no longer holds.

All limit comparisons are signed two's-complement on the top 11 bits of the 16-bit, left-justified result, so the finer resolution bits never move the alert or the flags. Configuration bit 5 is an active-low enable and bit 4 selects the pin polarity. The status byte reports the pin level together with both flags. The bus protocol and the converter are outside this block. It only sees register-write strobes, a status-read strobe, a conversion-done strobe and the clear pulse.

Top module: `thermal_alert`

## Requirements
- R1: The alert state and both flags are set only on a cycle where `conv_done` is high. Between conversions, changes to the limits do not raise the alert.
- R2: On `conv_done`, if `signed(conv_result[15:5]) > signed(upper[15:5])`, the alert becomes active from the next cycle. Equality does not set it.
- R3: On `conv_done`, a result strictly below the lower limit clears the alert. A result between the limits, or equal to either limit, leaves the alert unchanged.
- R4: A configuration write with bit 3 set clears the alert. Bit 3 always reads back as 0. If the next conversion is still above the upper limit, the alert is raised again.
- R5: A one-cycle `ara_clr` pulse clears the alert state.
- R6: The high flag (`stat_q` bit 2) sets when a conversion is above the upper limit. It clears only on a `stat_rd` cycle when the most recent result is not above the limit.
- R7: The low flag (`stat_q` bit 1) behaves the same way against the lower limit, using strict less-than.
- R8: Result bits 4:0 never affect the alert or the flags.
- R9: Configuration bit 5 = 1 disables the pin, which then sits at its inactive level. Bit 4 = 1 makes the pin active-high and 0 makes it active-low. The alert state keeps tracking the limits while the pin is disabled.
- R10: `stat_q` bit 3 equals the pin level, bit 2 is the high flag, bit 1 is the low flag, and all other bits are 0. The reset value is 08h.
- R11: After reset, the upper limit reads 7FE0h, the lower limit reads 8000h and the configuration reads 00h. Limit bits 4:0 always read 0.
- R12: A clear (R4 or R5) in the same cycle as a conversion wins over a set. A result that is both above the upper and below the lower limit sets the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new result is valid |
| conv_result | input | 16 | Left-justified two's-complement temperature |
| hi_wr | input | 1 | Write strobe for the upper limit |
| lo_wr | input | 1 | Write strobe for the lower limit |
| lim_wdata | input | 16 | Limit write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data (bit 5 disable, bit 4 polarity, bit 3 alert reset) |
| stat_rd | input | 1 | One-cycle strobe: status byte is being read |
| ara_clr | input | 1 | One-cycle external alert clear |
| alert_pin | output | 1 | Alert pin level |
| hi_lim_q | output | 16 | Upper limit readback |
| lo_lim_q | output | 16 | Lower limit readback |
| cfg_q | output | 8 | Configuration readback |
| stat_q | output | 8 | Status byte |

## Verification
A wrong alert state shows on `alert_pin` and on `stat_q` bit 3 one cycle after the conversion or clear that caused it, unless the pin is disabled. In that case it stays hidden until the enable returns, and then appears in the very next cycle. A flag that is stuck or cleared too early shows on `stat_q` one cycle after the read or conversion. A missing hysteresis only becomes visible once a result lands between the two limits. So the stimulus walks results across, onto and between both limits under both polarities, and compares every output against a behavioural model on every clock.

// File: rtl/tla_pkg.sv
// Package: shared bit positions for the configuration and status bytes.
// Assumes byte-wide configuration and status registers.
package tla_pkg;
    localparam int CFG_DIS_BIT = 5;   // 1 = pin forced inactive
    localparam int CFG_POL_BIT = 4;   // 1 = active-high
    localparam int CFG_CLR_BIT = 3;   // write 1 clears alert, reads 0
    localparam int ST_PIN_BIT  = 3;   // mirrors pin level
    localparam int ST_HI_BIT   = 2;   // sticky above-upper flag
    localparam int ST_LO_BIT   = 1;   // sticky below-lower flag
    localparam int N_FLAGS     = 2;
    localparam int FLAG_HI     = 0;
    localparam int FLAG_LO     = 1;
endpackage

// File: rtl/tla_limit_reg.sv
// Module: one limit register. Only the compared upper bits are stored;
// lower bits read back as zero. Assumes DATA_W > CMP_W.
module tla_limit_reg #(
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11,
    parameter logic [DATA_W-1:0] RST_VAL = 16'h7FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int LSB_W = DATA_W - CMP_W;

    logic [CMP_W-1:0] kept;
    logic             unused_low;

    // Purpose: hold the upper bits of the limit, reloading on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kept <= RST_VAL[DATA_W-1:LSB_W];
        else if (wr)
            kept <= wdata[DATA_W-1:LSB_W];
    end

    assign unused_low = ^wdata[LSB_W-1:0];
    assign q = {kept, {LSB_W{1'b0}}};
endmodule

// File: rtl/tla_window_cmp.sv
// Module: signed window comparator on the top CMP_W bits of a sample.
// Purely combinational; strict greater-than and strict less-than.
module tla_window_cmp #(
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    output logic              above,
    output logic              below
);
    localparam int LSB_W = DATA_W - CMP_W;

    logic signed [CMP_W-1:0] s_val, s_hi, s_lo;
    logic                    unused_fine;

    assign s_val = sample[DATA_W-1:LSB_W];
    assign s_hi  = hi_lim[DATA_W-1:LSB_W];
    assign s_lo  = lo_lim[DATA_W-1:LSB_W];
    assign unused_fine = ^{sample[LSB_W-1:0], hi_lim[LSB_W-1:0], lo_lim[LSB_W-1:0]};

    // Purpose: compare the sample against both limits.
    always_comb begin
        above = (s_val > s_hi);
        below = (s_val < s_lo);
    end
endmodule

// File: rtl/tla_sticky_flag.sv
// Module: sticky status flag. Set by an event; cleared by a read only
// while its condition is false. A set wins over a clear.
module tla_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_ev,
    input  logic cond_now,
    output logic flag
);
    // Purpose: set on the event, clear on a read once the condition is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (rd_ev && !cond_now)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tla_alert_ctl.sv
// Module: alert hysteresis state, configuration byte, sticky flags, pin
// and status byte. Assumes above/below are valid whenever conv_done is high.
module tla_alert_ctl
    import tla_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic              above,
    input  logic              below,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              stat_rd,
    input  logic              ara_clr,
    output logic              alert_pin,
    output logic              alert_state,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [STAT_W-1:0] stat_q
);
    logic               clear_req;
    logic               above_last, below_last;
    logic [N_FLAGS-1:0] set_v, cond_v, flag_v;
    logic               pin_active;

    assign clear_req = ara_clr | (cfg_wr & cfg_wdata[CFG_CLR_BIT]);

    // Purpose: configuration byte; the alert-reset bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr) begin
            cfg_q <= cfg_wdata;
            cfg_q[CFG_CLR_BIT] <= 1'b0;
        end
    end

    // Purpose: hysteresis alert state; clears win over a same-cycle set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alert_state <= 1'b0;
        else if (clear_req)
            alert_state <= 1'b0;
        else if (conv_done && above)
            alert_state <= 1'b1;
        else if (conv_done && below)
            alert_state <= 1'b0;
    end

    // Purpose: remember the outcome of the most recent conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above_last <= 1'b0;
            below_last <= 1'b0;
        end else if (conv_done) begin
            above_last <= above;
            below_last <= below;
        end
    end

    // Purpose: present each flag's set event and live condition.
    always_comb begin
        set_v[FLAG_HI]  = conv_done & above;
        set_v[FLAG_LO]  = conv_done & below;
        cond_v[FLAG_HI] = conv_done ? above : above_last;
        cond_v[FLAG_LO] = conv_done ? below : below_last;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        tla_sticky_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_ev   (set_v[g]),
            .rd_ev    (stat_rd),
            .cond_now (cond_v[g]),
            .flag     (flag_v[g])
        );
    end

    // Purpose: pin level from state, enable and polarity.
    always_comb begin
        pin_active = alert_state & ~cfg_q[CFG_DIS_BIT];
        alert_pin  = cfg_q[CFG_POL_BIT] ? pin_active : ~pin_active;
    end

    // Purpose: assemble the status byte.
    always_comb begin
        stat_q             = '0;
        stat_q[ST_PIN_BIT] = alert_pin;
        stat_q[ST_HI_BIT]  = flag_v[FLAG_HI];
        stat_q[ST_LO_BIT]  = flag_v[FLAG_LO];
    end
endmodule

// File: rtl/thermal_alert.sv
// Module: top of the temperature limit alert block. Wires the two limit
// registers, the window comparator and the alert controller. Assumes
// conv_done, stat_rd and ara_clr are single-cycle strobes.
module thermal_alert #(
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11,
    parameter int CFG_W  = 8,
    parameter int STAT_W = 8,
    parameter logic [DATA_W-1:0] HI_RST = 16'h7FE0,
    parameter logic [DATA_W-1:0] LO_RST = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic [DATA_W-1:0] lim_wdata,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              stat_rd,
    input  logic              ara_clr,
    output logic              alert_pin,
    output logic [DATA_W-1:0] hi_lim_q,
    output logic [DATA_W-1:0] lo_lim_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [STAT_W-1:0] stat_q
);
    logic above, below;
    logic alert_state;

    tla_limit_reg #(.DATA_W(DATA_W), .CMP_W(CMP_W), .RST_VAL(HI_RST)) u_hi (
        .clk(clk), .rst_n(rst_n), .wr(hi_wr), .wdata(lim_wdata), .q(hi_lim_q)
    );

    tla_limit_reg #(.DATA_W(DATA_W), .CMP_W(CMP_W), .RST_VAL(LO_RST)) u_lo (
        .clk(clk), .rst_n(rst_n), .wr(lo_wr), .wdata(lim_wdata), .q(lo_lim_q)
    );

    tla_window_cmp #(.DATA_W(DATA_W), .CMP_W(CMP_W)) u_cmp (
        .sample(conv_result), .hi_lim(hi_lim_q), .lo_lim(lo_lim_q),
        .above(above), .below(below)
    );

    tla_alert_ctl #(.CFG_W(CFG_W), .STAT_W(STAT_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .above       (above),
        .below       (below),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .stat_rd     (stat_rd),
        .ara_clr     (ara_clr),
        .alert_pin   (alert_pin),
        .alert_state (alert_state),
        .cfg_q       (cfg_q),
        .stat_q      (stat_q)
    );
endmodule

// File: rtl/thermal_alert_checker.sv
// Module: temporal checks on the alert block, bound to its top.
module thermal_alert_checker #(
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11,
    parameter int CFG_W  = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_result,
    input logic [DATA_W-1:0] hi_lim_q,
    input logic [DATA_W-1:0] lo_lim_q,
    input logic              cfg_wr,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              stat_rd,
    input logic              ara_clr,
    input logic              alert_state,
    input logic [STAT_W-1:0] stat_q
);
    localparam int LSB_W = DATA_W - CMP_W;

    logic signed [CMP_W-1:0] res_s, hi_s, lo_s;
    logic                    clr_now;

    assign res_s   = conv_result[DATA_W-1:LSB_W];
    assign hi_s    = hi_lim_q[DATA_W-1:LSB_W];
    assign lo_s    = lo_lim_q[DATA_W-1:LSB_W];
    assign clr_now = ara_clr | (cfg_wr & cfg_wdata[tla_pkg::CFG_CLR_BIT]);

    assert_set_only_on_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_state) |-> $past(conv_done));

    assert_above_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !clr_now && (res_s > hi_s)) |=> alert_state);

    assert_below_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !(res_s > hi_s) && (res_s < lo_s)) |=> !alert_state);

    assert_reset_bit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[tla_pkg::CFG_CLR_BIT]) |=> !alert_state);

    assert_ara_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ara_clr |=> !alert_state);

    assert_hi_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (res_s > hi_s)) |=> stat_q[tla_pkg::ST_HI_BIT]);

    assert_hi_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[tla_pkg::ST_HI_BIT]) |-> $past(stat_rd));

    assert_lo_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[tla_pkg::ST_LO_BIT]) |-> $past(stat_rd));
endmodule

bind thermal_alert thermal_alert_checker #(
    .DATA_W(DATA_W), .CMP_W(CMP_W), .CFG_W(CFG_W), .STAT_W(STAT_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .hi_lim_q    (hi_lim_q),
    .lo_lim_q    (lo_lim_q),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .stat_rd     (stat_rd),
    .ara_clr     (ara_clr),
    .alert_state (alert_state),
    .stat_q      (stat_q)
);

// File: tb/thermal_alert_test.sv
module thermal_alert_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0;
    logic [15:0] lim_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        stat_rd = 1'b0, ara_clr = 1'b0;
    logic        alert_pin;
    logic [15:0] hi_lim_q, lo_lim_q;
    logic [7:0]  cfg_q, stat_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_alert uut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .hi_wr(hi_wr), .lo_wr(lo_wr), .lim_wdata(lim_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .ara_clr(ara_clr),
        .alert_pin(alert_pin), .hi_lim_q(hi_lim_q), .lo_lim_q(lo_lim_q),
        .cfg_q(cfg_q), .stat_q(stat_q)
    );

    // Behavioural reference model
    logic [15:0] m_hi = 16'h7FE0, m_lo = 16'h8000;
    logic [7:0]  m_cfg = 8'h00;
    bit m_alert = 0, m_hf = 0, m_lf = 0, m_ab = 0, m_bl = 0;
    int m_sv;
    bit m_nab, m_nbl, m_hc, m_lc;

    function automatic int temp11(input logic [15:0] v);
        return int'($signed(v[15:5]));
    endfunction

    function automatic logic exp_pin();
        bit act;
        act = m_alert && !m_cfg[5];
        return m_cfg[4] ? act : !act;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 16'h7FE0; m_lo = 16'h8000; m_cfg = 8'h00;
            m_alert = 0; m_hf = 0; m_lf = 0; m_ab = 0; m_bl = 0;
        end else begin
            m_sv  = temp11(conv_result);
            m_nab = conv_done && (m_sv > temp11(m_hi));
            m_nbl = conv_done && (m_sv < temp11(m_lo));
            m_hc  = conv_done ? m_nab : m_ab;
            m_lc  = conv_done ? m_nbl : m_bl;
            if (m_nab) m_alert = 1;
            else if (m_nbl) m_alert = 0;
            if (ara_clr || (cfg_wr && cfg_wdata[3])) m_alert = 0;
            if (m_nab) m_hf = 1; else if (stat_rd && !m_hc) m_hf = 0;
            if (m_nbl) m_lf = 1; else if (stat_rd && !m_lc) m_lf = 0;
            if (conv_done) begin m_ab = m_nab; m_bl = m_nbl; end
            if (hi_wr) m_hi = lim_wdata & 16'hFFE0;
            if (lo_wr) m_lo = lim_wdata & 16'hFFE0;
            if (cfg_wr) m_cfg = cfg_wdata & 8'hF7;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R9 model pin", {15'b0, alert_pin}, {15'b0, exp_pin()});
        chk("R10 model status", {8'b0, stat_q},
            {8'b0, 4'b0, exp_pin(), m_hf, m_lf, 1'b0});
        chk("R11 model upper", hi_lim_q, m_hi);
        chk("R11 model lower", lo_lim_q, m_lo);
        chk("R4 model cfg", {8'b0, cfg_q}, {8'b0, m_cfg});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic conv(input logic [15:0] v);
        conv_done = 1; conv_result = v; tick(); conv_done = 0;
    endtask

    task automatic wr_hi(input logic [15:0] v);
        hi_wr = 1; lim_wdata = v; tick(); hi_wr = 0;
    endtask

    task automatic wr_lo(input logic [15:0] v);
        lo_wr = 1; lim_wdata = v; tick(); lo_wr = 0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
    endtask

    task automatic rd_stat();
        stat_rd = 1; tick(); stat_rd = 0;
    endtask

    task automatic ara();
        ara_clr = 1; tick(); ara_clr = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 R11 reset values
        chk("R10 reset status", {8'b0, stat_q}, 16'h0008);
        chk("R11 reset upper", hi_lim_q, 16'h7FE0);
        chk("R11 reset lower", lo_lim_q, 16'h8000);
        chk("R11 reset cfg", {8'b0, cfg_q}, 16'h0000);

        wr_hi(16'h191F);
        chk("R11 upper low bits zero", hi_lim_q, 16'h1900);
        wr_lo(16'h0C80);

        conv(16'h1900);
        chk("R2 equal does not set", {15'b0, alert_pin}, 16'h1);
        conv(16'h191F);
        chk("R8 fine bits ignored", {15'b0, alert_pin}, 16'h1);
        chk("R8 fine bits no flag", {8'b0, stat_q}, 16'h0008);
        conv(16'h1920);
        chk("R2 above sets (active low)", {15'b0, alert_pin}, 16'h0);
        chk("R10 status pin and high flag", {8'b0, stat_q}, 16'h0004);

        // R1 limit change between conversions does nothing
        wr_hi(16'h7FE0);
        wr_hi(16'h1900);
        tick();
        chk("R1 held between conversions", {15'b0, alert_pin}, 16'h0);
        conv(16'h1000);
        chk("R3 hysteresis holds", {15'b0, alert_pin}, 16'h0);
        chk("R6 high flag sticky", {13'b0, stat_q[2]}, 16'h1);
        rd_stat();
        chk("R6 read clears high flag", {13'b0, stat_q[2]}, 16'h0);

        conv(16'h0C80);
        chk("R3 equal to lower holds", {15'b0, alert_pin}, 16'h0);
        conv(16'h0C60);
        chk("R3 below clears", {15'b0, alert_pin}, 16'h1);
        chk("R7 low flag sets", {13'b0, stat_q[1]}, 16'h1);
        rd_stat();
        chk("R7 read while below keeps flag", {13'b0, stat_q[1]}, 16'h1);
        conv(16'h1000);
        rd_stat();
        chk("R7 read after recovery clears", {13'b0, stat_q[1]}, 16'h0);

        conv(16'h2000);
        chk("R2 set again", {15'b0, alert_pin}, 16'h0);
        wr_cfg(8'h08);
        chk("R4 reset bit clears", {15'b0, alert_pin}, 16'h1);
        chk("R4 reset bit reads 0", {8'b0, cfg_q}, 16'h0000);
        conv(16'h2000);
        chk("R4 reasserts on next conversion", {15'b0, alert_pin}, 16'h0);
        ara();
        chk("R5 ara clears", {15'b0, alert_pin}, 16'h1);

        wr_cfg(8'h10);
        chk("R9 active-high idle", {15'b0, alert_pin}, 16'h0);
        conv(16'h2000);
        chk("R9 active-high asserted", {15'b0, alert_pin}, 16'h1);
        wr_cfg(8'h30);
        chk("R9 disabled inactive", {15'b0, alert_pin}, 16'h0);
        conv(16'h0000);
        wr_cfg(8'h10);
        chk("R9 state tracked while disabled (clear)", {15'b0, alert_pin}, 16'h0);
        wr_cfg(8'h30);
        conv(16'h2000);
        chk("R9 disabled hides set", {15'b0, alert_pin}, 16'h0);
        wr_cfg(8'h10);
        chk("R9 state tracked while disabled (set)", {15'b0, alert_pin}, 16'h1);
        wr_cfg(8'h00);
        chk("R9 back to active-low", {15'b0, alert_pin}, 16'h0);
        ara();

        ara_clr = 1; conv(16'h2000); ara_clr = 0;
        chk("R12 clear wins over set", {15'b0, alert_pin}, 16'h1);
        wr_hi(16'h0000);
        wr_lo(16'h1000);
        conv(16'h0800);
        chk("R12 above wins over below", {15'b0, alert_pin}, 16'h0);
        ara();

        wr_hi(16'hF380);
        wr_lo(16'hEC00);
        conv(16'hFF80);
        chk("R2 signed compare above", {15'b0, alert_pin}, 16'h0);
        conv(16'hE000);
        chk("R3 signed compare below", {15'b0, alert_pin}, 16'h1);
        rd_stat();
        rd_stat();
        repeat (4) tick();

        finish_run();
    end
endmodule